// File: doc/BRIEF.md
# Parallel display bus timing engine

This block drives asynchronous 8080-style bus cycles toward an external display controller. Each cycle moves one command word, one parameter word or one read word over a bidirectional data bus, framed by an active-low chip select and an active-low write or read strobe. A data/command select line tells the controller which kind of word a write carries.

A host starts a cycle with a one-clock request that carries a target select and a data word. Every strobe edge is set by its own tick value. Cycle lengths and the read sampling point are also tick values, taken from two packed timing words. The block corrects timing values that are out of order before it uses them. A tick is one clock, or two clocks when the divider input is set. The bus can be 16 bits or 8 bits wide. The host sees a busy flag and the last word the bus returned.

Top module: `pbus_engine`

## Requirements
- R1: After reset the chip select, write strobe and read strobe are high, the select line is high, busy is low and the returned read data is zero.
- R2: A request with target select 0 starts a command cycle. During it the select line is low, the write strobe pulses, the read strobe stays high and the request word is driven on the bus with the output enable high.
- R3: A request with target select 1 starts a parameter cycle. It is the same as a command cycle, except that the select line is high.
- R4: A request with target select 2 starts a read cycle. The select line is high and the write strobe stays high. The bus is not driven and the read strobe pulses. The bus value is captured on the tick that ends the tick whose count equals the access time, provided the access time is below the cycle length. The captured value is held on the read data output until the next capture. The two strobes are never low together.
- R5: A per-cycle tick counter starts at 0. A strobe is low while the counter is at or above the strobe's on value and below both its off value and the cycle length. Chip select follows this rule in every cycle.
- R6: Busy rises on the clock that accepts a request. It stays high for exactly L ticks, where L is the write cycle length for command and parameter cycles and the read cycle length for read cycles.
- R7: When the divider input is high, one tick lasts two clocks. All strobe positions, busy lengths and the capture point scale by two.
- R8: When the width input is 3 the bus is 16 bits wide. Any other value selects 8 bits: only the low byte is driven, and the upper byte of the bus output and of the captured read data is zero.
- R9: A request made while busy is ignored, and so is a request with target select 3. Neither starts a cycle or changes the returned read data.
- R10: In the on/off word, chip-select on is bits [3:0] and off is bits [9:4]. Write on is [13:10] and off is [19:14]. Read on is [23:20] and off is [29:24]. In the cycle word, the write length is bits [5:0], the read length is [11:6] and the access time is [27:22]. Bits [17:12] of the cycle word hold a chip-select pulse width that the block does not use.
- R11: Before use, the timing values are corrected in this order:
  - each off value not above its on value becomes on+1;
  - chip-select off is raised to the larger of the corrected write and read off values;
  - the write and read lengths are raised to the corrected write and read off values;
  - an access time not above read-on becomes read-on+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-clock host request |
| req_sel_i | input | 2 | Target select: 0 command, 1 parameter, 2 read, 3 none |
| req_data_i | input | 16 | Word to write |
| cfg_width_i | input | 2 | Bus width code, 3 selects 16 bits |
| cfg_div2_i | input | 1 | Tick is two clocks when high |
| onoff_word_i | input | 32 | Packed strobe on/off tick values |
| cycle_word_i | input | 32 | Packed cycle lengths and access time |
| busy_o | output | 1 | Cycle in progress |
| rd_data_o | output | 16 | Last captured read word |
| cs_no | output | 1 | Chip select, active low |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| dc_o | output | 1 | Low for command, high otherwise |
| bus_data_o | output | 16 | Bus drive value |
| bus_oe_o | output | 1 | Bus drive enable |
| bus_data_i | input | 16 | Bus value from the controller |

## Verification
The bench builds the engine with its default 16-bit data parameter. It switches the width code and the divider at run time, so one build covers both bus widths and both tick lengths. A bus value that counts clocks lets each read result reveal the exact clock on which it was captured. Timing sets are chosen to reach the corrected-order path and an off value beyond the cycle end. They also include strobes that start at tick zero.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ON_W   = 4;
  localparam int OFF_W  = 6;
  localparam int CNT_W  = OFF_W;
  localparam int WORD_W = 32;
  localparam int NSTB   = 3;

  // on/off word field positions
  localparam int CS_ON_LSB  = 0;
  localparam int CS_OFF_LSB = 4;
  localparam int WE_ON_LSB  = 10;
  localparam int WE_OFF_LSB = 14;
  localparam int RE_ON_LSB  = 20;
  localparam int RE_OFF_LSB = 24;
  // cycle word field positions
  localparam int WR_LEN_LSB = 0;
  localparam int RD_LEN_LSB = 6;
  localparam int ACC_LSB    = 22;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_PARAM = 2'd1,
    K_READ  = 2'd2,
    K_NONE  = 2'd3
  } kind_e;

  typedef struct packed {
    logic [CNT_W-1:0] cs_on;
    logic [CNT_W-1:0] cs_off;
    logic [CNT_W-1:0] we_on;
    logic [CNT_W-1:0] we_off;
    logic [CNT_W-1:0] re_on;
    logic [CNT_W-1:0] re_off;
    logic [CNT_W-1:0] wr_len;
    logic [CNT_W-1:0] rd_len;
    logic [CNT_W-1:0] acc;
  } timing_t;
endpackage

// File: rtl/pbus_timing_fix.sv
module pbus_timing_fix
  import pbus_pkg::*;
(
  input  logic [WORD_W-1:0] onoff_i,
  input  logic [WORD_W-1:0] cycle_i,
  output timing_t           tm_o
);
  localparam int PAD = CNT_W - ON_W;

  function automatic logic [CNT_W-1:0] past_on(logic [CNT_W-1:0] on, logic [CNT_W-1:0] off);
    return (off <= on) ? on + 1'b1 : off;
  endfunction

  function automatic logic [CNT_W-1:0] at_least(logic [CNT_W-1:0] v, logic [CNT_W-1:0] floor);
    return (v < floor) ? floor : v;
  endfunction

  logic [CNT_W-1:0] cs_on, we_on, re_on;
  logic [CNT_W-1:0] we_off_f, re_off_f, cs_off_f;
  logic unused_bits;

  assign cs_on = {{PAD{1'b0}}, onoff_i[CS_ON_LSB +: ON_W]};
  assign we_on = {{PAD{1'b0}}, onoff_i[WE_ON_LSB +: ON_W]};
  assign re_on = {{PAD{1'b0}}, onoff_i[RE_ON_LSB +: ON_W]};

  assign we_off_f = past_on(we_on, onoff_i[WE_OFF_LSB +: OFF_W]);
  assign re_off_f = past_on(re_on, onoff_i[RE_OFF_LSB +: OFF_W]);
  assign cs_off_f = at_least(past_on(cs_on, onoff_i[CS_OFF_LSB +: OFF_W]),
                             at_least(we_off_f, re_off_f));

  always_comb begin
    tm_o.cs_on  = cs_on;
    tm_o.cs_off = cs_off_f;
    tm_o.we_on  = we_on;
    tm_o.we_off = we_off_f;
    tm_o.re_on  = re_on;
    tm_o.re_off = re_off_f;
    tm_o.wr_len = at_least(cycle_i[WR_LEN_LSB +: OFF_W], we_off_f);
    tm_o.rd_len = at_least(cycle_i[RD_LEN_LSB +: OFF_W], re_off_f);
    tm_o.acc    = past_on(re_on, cycle_i[ACC_LSB +: OFF_W]);
  end

  // pulse-width field and spare bits carry no function here
  assign unused_bits = ^{onoff_i[WORD_W-1:RE_OFF_LSB+OFF_W],
                         cycle_i[WORD_W-1:ACC_LSB+OFF_W],
                         cycle_i[ACC_LSB-1:RD_LEN_LSB+OFF_W]};
endmodule

// File: rtl/pbus_tick_div.sv
module pbus_tick_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic div2_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (!run_i) phase_q <= 1'b0;
    else             phase_q <= ~phase_q;
  end

  assign tick_o = run_i & (~div2_i | phase_q);

  assert_tick_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div2_i && tick_o) |=> !tick_o);
endmodule

// File: rtl/pbus_strobe.sv
module pbus_strobe #(
  parameter int CNT_W = 6
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             strobe_no
);
  assign strobe_no = ~(en_i && (cnt_i >= on_i) && (cnt_i < off_i));
endmodule

// File: rtl/pbus_engine.sv
module pbus_engine
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        req_sel_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [1:0]        cfg_width_i,
  input  logic              cfg_div2_i,
  input  logic [WORD_W-1:0] onoff_word_i,
  input  logic [WORD_W-1:0] cycle_word_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cs_no,
  output logic              we_no,
  output logic              re_no,
  output logic              dc_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] bus_data_i
);
  localparam int HI_W = DATA_W - NARROW_W;
  localparam int S_CS = 0;
  localparam int S_WE = 1;
  localparam int S_RE = 2;

  timing_t           tm;
  logic              active_q;
  kind_e             kind_q;
  logic [DATA_W-1:0] data_q, rd_q;
  logic [CNT_W-1:0]  cnt_q, cyc_len;
  logic [CNT_W:0]    cnt_nxt;
  logic              tick, wide, accept, is_rd, sample;
  logic [DATA_W-1:0] wr_fit, rd_fit;

  logic [CNT_W-1:0]  st_on  [NSTB];
  logic [CNT_W-1:0]  st_off [NSTB];
  logic [NSTB-1:0]   st_en, st_n;

  pbus_timing_fix u_fix (
    .onoff_i (onoff_word_i),
    .cycle_i (cycle_word_i),
    .tm_o    (tm)
  );

  pbus_tick_div u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active_q),
    .div2_i (cfg_div2_i),
    .tick_o (tick)
  );

  assign wide    = (cfg_width_i == 2'd3);
  assign accept  = req_i && !active_q && (kind_e'(req_sel_i) != K_NONE);
  assign is_rd   = (kind_q == K_READ);
  assign cyc_len = is_rd ? tm.rd_len : tm.wr_len;
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign sample  = active_q && tick && is_rd && (cnt_q == tm.acc);

  assign wr_fit = wide ? req_data_i : {{HI_W{1'b0}}, req_data_i[NARROW_W-1:0]};
  assign rd_fit = wide ? bus_data_i : {{HI_W{1'b0}}, bus_data_i[NARROW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= K_NONE;
      data_q   <= '0;
      cnt_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      kind_q   <= kind_e'(req_sel_i);
      data_q   <= wr_fit;
      cnt_q    <= '0;
    end else if (active_q && tick) begin
      if (cnt_nxt >= {1'b0, cyc_len}) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_nxt[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (sample) rd_q <= rd_fit;
  end

  always_comb begin
    st_en[S_CS] = active_q;
    st_on[S_CS] = tm.cs_on;
    st_off[S_CS] = tm.cs_off;
    st_en[S_WE] = active_q && !is_rd;
    st_on[S_WE] = tm.we_on;
    st_off[S_WE] = tm.we_off;
    st_en[S_RE] = active_q && is_rd;
    st_on[S_RE] = tm.re_on;
    st_off[S_RE] = tm.re_off;
  end

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    pbus_strobe #(.CNT_W(CNT_W)) u_stb (
      .en_i      (st_en[g]),
      .cnt_i     (cnt_q),
      .on_i      (st_on[g]),
      .off_i     (st_off[g]),
      .strobe_no (st_n[g])
    );
  end

  assign cs_no      = st_n[S_CS];
  assign we_no      = st_n[S_WE];
  assign re_no      = st_n[S_RE];
  assign dc_o       = ~(active_q && (kind_q == K_CMD));
  assign bus_oe_o   = active_q && !is_rd;
  assign bus_data_o = bus_oe_o ? data_q : '0;
  assign busy_o     = active_q;
  assign rd_data_o  = rd_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && we_no && re_no && dc_o));
  assert_single_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < cyc_len));
  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && req_i) |=> ($stable(kind_q) && $stable(data_q)));
  assert_narrow_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide && busy_o) |-> (bus_data_o[DATA_W-1:NARROW_W] == '0));
endmodule

// File: tb/test_pbus_engine.sv
module test_pbus_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req, div2, busy, cs_n, we_n, re_n, dc, boe;
  logic [1:0]  sel, width;
  logic [15:0] wdata, rd, bdo, bdi;
  logic [31:0] onoff, cyc;
  logic [15:0] stamp = '0;

  always @(negedge clk) stamp <= stamp + 16'd1;
  assign bdi = stamp;

  pbus_engine i_pbus_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_sel_i(sel), .req_data_i(wdata),
    .cfg_width_i(width), .cfg_div2_i(div2), .onoff_word_i(onoff), .cycle_word_i(cyc),
    .busy_o(busy), .rd_data_o(rd), .cs_no(cs_n), .we_no(we_n), .re_no(re_n), .dc_o(dc),
    .bus_data_o(bdo), .bus_oe_o(boe), .bus_data_i(bdi)
  );

  typedef struct {
    int len; int d; int dc; int data; int rd;
    int lo0; int n0; int lo1; int n1; int lo2; int n2;
    string tl; string tw; string tr; string td;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0, exp_rd = 0;
  int t_cs_on, t_cs_off, t_we_on, t_we_off, t_re_on, t_re_off, t_wl, t_rl, t_acc;
  string tag_ovr = "";
  bit done = 0;

  task automatic check(bit ok, string r, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic set_timing(int cson, int csoff, int weon, int weoff, int reon, int reoff,
                            int wl, int rl, int acc);
    onoff = 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) | (32'(weoff) << 14) |
            (32'(reon) << 20) | (32'(reoff) << 24);
    cyc = 32'(wl) | (32'(rl) << 6) | (32'h15 << 12) | (32'(acc) << 22);
    // R11 correction model
    t_we_on = weon; t_we_off = (weoff <= weon) ? weon + 1 : weoff;
    t_re_on = reon; t_re_off = (reoff <= reon) ? reon + 1 : reoff;
    t_cs_on = cson; t_cs_off = (csoff <= cson) ? cson + 1 : csoff;
    if (t_cs_off < t_we_off) t_cs_off = t_we_off;
    if (t_cs_off < t_re_off) t_cs_off = t_re_off;
    t_wl  = (wl < t_we_off) ? t_we_off : wl;
    t_rl  = (rl < t_re_off) ? t_re_off : rl;
    t_acc = (acc <= reon) ? reon + 1 : acc;
  endtask

  task automatic span(int on, int off, int len, int d, bit en, output int lo, output int n);
    int hi;
    hi = (off < len) ? off : len;
    if (!en || on >= hi) begin lo = -1; n = 0; end
    else begin lo = d * on; n = d * (hi - on); end
  endtask

  task automatic issue(int s, int data, bit expect_go);
    exp_t it;
    int s0;
    bit w16;
    @(negedge clk); #1;
    req = 1'b1; sel = 2'(s); wdata = 16'(data); s0 = int'(stamp);
    if (expect_go) begin
      w16  = (width == 2'd3);
      it.d = div2 ? 2 : 1;
      it.len = (s == 2) ? t_rl : t_wl;
      span(t_cs_on, t_cs_off, it.len, it.d, 1'b1, it.lo0, it.n0);
      span(t_we_on, t_we_off, it.len, it.d, s != 2, it.lo1, it.n1);
      span(t_re_on, t_re_off, it.len, it.d, s == 2, it.lo2, it.n2);
      it.dc   = (s == 0) ? 0 : 1;
      it.data = (s == 2) ? 0 : (w16 ? (data & 16'hffff) : (data & 8'hff));
      if (s == 2 && t_acc < t_rl)
        exp_rd = (s0 + it.d * (t_acc + 1)) & (w16 ? 16'hffff : 16'h00ff);
      it.rd = exp_rd;
      it.tl = (it.d == 2) ? "R7" : "R6";
      it.tw = (s == 0) ? "R2" : "R3";
      it.tr = "R4";
      it.td = w16 ? it.tw : "R8";
      if (tag_ovr != "") begin
        it.tl = tag_ovr; it.tw = tag_ovr; it.tr = tag_ovr; it.td = tag_ovr;
      end
      q.push_back(it);
    end
    @(negedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
  endtask

  // monitor: measures each bus cycle, compares with the oldest expected item
  int  m_idx, m_dc, m_data;
  int  m_lo [3];
  int  m_n  [3];
  bit  prev_busy = 1'b0;
  always @(negedge clk) begin
    exp_t it;
    logic [2:0] s;
    if (busy) begin
      if (!prev_busy) begin
        m_idx = 0; m_dc = int'(dc); m_data = boe ? int'(bdo) : 0;
        for (int i = 0; i < 3; i++) begin m_lo[i] = -1; m_n[i] = 0; end
      end
      s = {re_n, we_n, cs_n};
      for (int i = 0; i < 3; i++)
        if (!s[i]) begin
          if (m_lo[i] < 0) m_lo[i] = m_idx;
          m_n[i]++;
        end
      m_idx++;
    end else if (prev_busy) begin
      if (q.size() == 0) check(1'b0, "R9 unexpected cycle", m_idx, 0);
      else begin
        it = q.pop_front();
        check(m_idx == it.d * it.len, it.tl, m_idx, it.d * it.len);
        check(m_lo[0] == it.lo0 && m_n[0] == it.n0, "R5/R10 cs", m_lo[0] * 256 + m_n[0], it.lo0 * 256 + it.n0);
        check(m_lo[1] == it.lo1 && m_n[1] == it.n1, it.tw, m_lo[1] * 256 + m_n[1], it.lo1 * 256 + it.n1);
        check(m_lo[2] == it.lo2 && m_n[2] == it.n2, it.tr, m_lo[2] * 256 + m_n[2], it.lo2 * 256 + it.n2);
        check(m_dc == it.dc, it.tw, m_dc, it.dc);
        check(m_data == it.data, it.td, m_data, it.data);
        check(int'(rd) == it.rd, it.tr, int'(rd), it.rd);
      end
    end
    prev_busy = busy;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual busy stuck expected idle");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; sel = '0; wdata = '0; width = 2'd3; div2 = 1'b0;
    set_timing(1, 8, 2, 6, 1, 7, 9, 10, 5);
    repeat (3) @(negedge clk); #1;
    check(cs_n && we_n && re_n, "R1 strobes", {cs_n, we_n, re_n}, 3'b111);
    check(!busy && dc, "R1 busy/dc", {busy, dc}, 2'b01);
    check(rd == 16'h0, "R1 rd", rd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // 16-bit, single clock ticks
    issue(0, 'h1234, 1); wait_idle();
    issue(1, 'hbeef, 1); wait_idle();
    issue(2, 0, 1);      wait_idle();

    // two-clock ticks
    div2 = 1'b1;
    issue(0, 'h5a5a, 1); wait_idle();
    issue(2, 0, 1);      wait_idle();
    div2 = 1'b0;

    // 8-bit bus
    width = 2'd0;
    issue(1, 'habcd, 1); wait_idle();
    issue(2, 0, 1);      wait_idle();
    issue(0, 'h0102, 1); wait_idle();
    width = 2'd3;

    // out-of-order timing values
    tag_ovr = "R11";
    set_timing(2, 1, 5, 3, 4, 0, 2, 8, 1);
    issue(0, 'h7777, 1); wait_idle();
    issue(2, 0, 1);      wait_idle();

    // chip-select off beyond cycle end, strobes from tick zero
    tag_ovr = "R5";
    set_timing(0, 40, 0, 3, 0, 3, 4, 4, 2);
    issue(1, 'h0f0f, 1); wait_idle();
    issue(2, 0, 1);      wait_idle();

    // ignored requests
    tag_ovr = "";
    set_timing(1, 8, 2, 6, 1, 7, 9, 10, 5);
    issue(0, 'h1111, 1);
    issue(1, 'h2222, 0);
    wait_idle();
    issue(3, 'h3333, 0);
    check(!busy, "R9 select 3", busy, 0);
    wait_idle();
    check(q.size() == 0, "R9 queue", q.size(), 0);
    check(int'(rd) == exp_rd, "R9 rd", int'(rd), exp_rd);

    done = 1'b1;
    report();
    $finish;
  end
endmodule